// File: doc/BRIEF.md
# PTP Time-of-Day Counter

This block keeps a precision time-of-day clock: a 48-bit seconds counter, a 30-bit nanoseconds counter and a 24-bit sub-nanosecond fraction accumulator. All three move forward on every edge of the timer clock. Each edge adds a whole-nanosecond step, and one extra nanosecond whenever the fraction accumulator overflows. The current seconds and nanoseconds are driven straight from the counter registers, so timestamping logic nearby can sample them directly.

Software reaches the block through a 32-bit register port. A write takes one cycle. A read returns its data one cycle after the request. Through this port software can do four things. It can load the time, with the seconds value committed as a whole when the low seconds word is written. It can program the rate, with the fractional part held pending until the whole-nanosecond step is written. It can move the time once by a signed offset smaller than one second. It can read back the live time and the active rate.

Top module: `ptp_tod_unit`

## Requirements
- R1: After synchronous reset, seconds, nanoseconds, both active increments and the fraction accumulator are zero, and `rd_valid` is low.
- R2: While the active ns step and the active sub-ns step are both zero, the time outputs hold their values on every edge that has no register write.
- R3: A write to offset 2 (data bits [15:0]) only stores the upper seconds and leaves the time unchanged. A following write to offset 1 loads seconds = {stored upper, data[31:0]} on that edge.
- R4: A write to offset 0 loads nanoseconds from data[29:0] on that edge, and seconds do not change on that edge.
- R5: A write to offset 3 holds a pending 24-bit sub-ns step, with data[15:0] carrying step bits [23:8] and data[31:24] carrying bits [7:0]. It does not change the rate. A write to offset 4 makes data[7:0] the active ns step and the pending value the active sub-ns step. Both are used from the next edge on.
- R6: On each edge, nanoseconds advance by the active ns step plus the carry out of (fraction + active sub-ns step) modulo 2^24.
- R7: When nanoseconds reach 1,000,000,000 or more, 1,000,000,000 is subtracted and seconds increase by one.
- R8: A write to offset 5 applies data[29:0] once as an offset, together with that edge's step. Bit 31 set means subtract. A result below zero borrows one second and a result of one second or more carries. The magnitude must be below one second.
- R9: With `rd_en` high, `rd_data` shows the register at `rd_addr` one cycle later and `rd_valid` is high. Offsets 0, 1 and 2 return the live nanoseconds, seconds[31:0] and seconds[47:32]. Offsets 3 and 4 return the active steps in their write layout. Offset 5 returns zero.
- R10: `tod_sec` and `tod_ns` are registered and change only on a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Read data, one cycle after request |
| rd_valid | output | 1 | High in the cycle `rd_data` is valid |
| tod_sec | output | 48 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
A write lands on the edge that samples it, so `tod_sec` and `tod_ns` are compared at the falling edge right after that edge. Increment writes only affect the steps taken from the following edge, so the bench counts every edge between the commit and the write that stops the clock, and from that count it derives the expected nanoseconds, including the fraction carries and the wrap into seconds. Read results come one cycle after the request. Each read pushes its expected word into a scoreboard queue, and a monitor pops and compares at the falling edge when `rd_valid` is high.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int unsigned AW = 3;
  localparam logic [AW-1:0] A_NS     = 3'd0;
  localparam logic [AW-1:0] A_SEC_LO = 3'd1;
  localparam logic [AW-1:0] A_SEC_HI = 3'd2;
  localparam logic [AW-1:0] A_SUBNS  = 3'd3;
  localparam logic [AW-1:0] A_NSINC  = 3'd4;
  localparam logic [AW-1:0] A_ADJ    = 3'd5;
  localparam int unsigned ADJ_SIGN_BIT = 31;
endpackage

// File: rtl/ptp_tod_incr.sv
module ptp_tod_incr #(
  parameter int unsigned SUB_W = 24,
  parameter int unsigned INC_W = 8,
  parameter int unsigned HI_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_sub,
  input  logic             ld_inc,
  input  logic [31:0]      wdata,
  output logic [SUB_W-1:0] act_sub,
  output logic [INC_W-1:0] act_ns,
  output logic [INC_W:0]   step,
  output logic [31:0]      sub_word
);
  localparam int unsigned LO_W  = SUB_W - HI_W;
  localparam int unsigned PAD_W = 32 - HI_W - LO_W;

  logic [SUB_W-1:0] pend_sub;
  logic [SUB_W-1:0] frac;
  logic [SUB_W:0]   frac_sum;

  assign frac_sum = {1'b0, frac} + {1'b0, act_sub};
  assign step     = {1'b0, act_ns} + {{INC_W{1'b0}}, frac_sum[SUB_W]};
  assign sub_word = {act_sub[LO_W-1:0], {PAD_W{1'b0}}, act_sub[SUB_W-1:LO_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sub <= '0;
      act_sub  <= '0;
      act_ns   <= '0;
      frac     <= '0;
    end else begin
      frac <= frac_sum[SUB_W-1:0];
      if (ld_sub) pend_sub <= {wdata[HI_W-1:0], wdata[31 -: LO_W]};
      if (ld_inc) begin
        act_ns  <= wdata[INC_W-1:0];
        act_sub <= pend_sub;
      end
    end
  end
endmodule

// File: rtl/ptp_tod_norm.sv
module ptp_tod_norm #(
  parameter int unsigned NS_W    = 30,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input  logic              [NS_W-1:0] ns_cur,
  input  logic              [INC_W:0]  step,
  input  logic                         adj_en,
  input  logic                         adj_neg,
  input  logic              [NS_W-1:0] adj_mag,
  output logic              [NS_W-1:0] ns_nxt,
  output logic signed       [2:0]      sec_adj
);
  localparam int unsigned SW = NS_W + 3;
  localparam logic signed [SW-1:0] WRAP1 = SW'(NS_WRAP);
  localparam logic signed [SW-1:0] WRAP2 = SW'(2 * longint'(NS_WRAP));

  logic signed [SW-1:0] base, mag, t, r;

  always_comb begin
    base = $signed({3'b000, ns_cur}) + $signed({{(SW-INC_W-1){1'b0}}, step});
    mag  = $signed({3'b000, adj_mag});
    if (!adj_en)      t = base;
    else if (adj_neg) t = base - mag;
    else              t = base + mag;
    if (t < 0) begin
      r = t + WRAP1;  sec_adj = -3'sd1;
    end else if (t >= WRAP2) begin
      r = t - WRAP2;  sec_adj = 3'sd2;
    end else if (t >= WRAP1) begin
      r = t - WRAP1;  sec_adj = 3'sd1;
    end else begin
      r = t;          sec_adj = 3'sd0;
    end
    ns_nxt = r[NS_W-1:0];
  end
endmodule

// File: rtl/ptp_tod_unit.sv
module ptp_tod_unit #(
  parameter int unsigned SEC_HI_W = 16,
  parameter int unsigned NS_W     = 30,
  parameter int unsigned SUB_W    = 24,
  parameter int unsigned INC_W    = 8,
  parameter int unsigned NS_WRAP  = 1_000_000_000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [2:0]               wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     rd_en,
  input  logic [2:0]               rd_addr,
  output logic [31:0]              rd_data,
  output logic                     rd_valid,
  output logic [32+SEC_HI_W-1:0]   tod_sec,
  output logic [NS_W-1:0]          tod_ns
);
  import ptp_tod_pkg::*;
  localparam int unsigned SEC_W = 32 + SEC_HI_W;

  logic [SEC_HI_W-1:0] sec_hi_hold;
  logic [SUB_W-1:0]    act_sub;
  logic [INC_W-1:0]    act_ns;
  logic [INC_W:0]      step;
  logic [31:0]         sub_word;
  logic [NS_W-1:0]     ns_nxt;
  logic signed [2:0]   sec_adj;
  logic                wr_ns, wr_slo, wr_shi, wr_sub, wr_inc, wr_adj;

  assign wr_ns  = wr_en && (wr_addr == A_NS);
  assign wr_slo = wr_en && (wr_addr == A_SEC_LO);
  assign wr_shi = wr_en && (wr_addr == A_SEC_HI);
  assign wr_sub = wr_en && (wr_addr == A_SUBNS);
  assign wr_inc = wr_en && (wr_addr == A_NSINC);
  assign wr_adj = wr_en && (wr_addr == A_ADJ);

  ptp_tod_incr #(.SUB_W(SUB_W), .INC_W(INC_W), .HI_W(16)) u_incr (
    .clk(clk), .rst(rst), .ld_sub(wr_sub), .ld_inc(wr_inc), .wdata(wr_data),
    .act_sub(act_sub), .act_ns(act_ns), .step(step), .sub_word(sub_word)
  );

  ptp_tod_norm #(.NS_W(NS_W), .INC_W(INC_W), .NS_WRAP(NS_WRAP)) u_norm (
    .ns_cur(tod_ns), .step(step), .adj_en(wr_adj),
    .adj_neg(wr_data[ADJ_SIGN_BIT]), .adj_mag(wr_data[NS_W-1:0]),
    .ns_nxt(ns_nxt), .sec_adj(sec_adj)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_sec     <= '0;
      tod_ns      <= '0;
      sec_hi_hold <= '0;
    end else begin
      if (wr_shi) sec_hi_hold <= wr_data[SEC_HI_W-1:0];
      if (wr_ns) begin
        tod_ns <= wr_data[NS_W-1:0];
      end else begin
        tod_ns <= ns_nxt;
      end
      if (wr_slo)
        tod_sec <= {sec_hi_hold, wr_data};
      else if (!wr_ns)
        tod_sec <= tod_sec + {{(SEC_W-3){sec_adj[2]}}, sec_adj};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          A_NS:     rd_data <= 32'(tod_ns);
          A_SEC_LO: rd_data <= tod_sec[31:0];
          A_SEC_HI: rd_data <= 32'(tod_sec[SEC_W-1:32]);
          A_SUBNS:  rd_data <= sub_word;
          A_NSINC:  rd_data <= 32'(act_ns);
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ptp_tod_chk.sv
module ptp_tod_chk #(
  parameter int unsigned SEC_W   = 48,
  parameter int unsigned NS_W    = 30,
  parameter int unsigned SUB_W   = 24,
  parameter int unsigned INC_W   = 8,
  parameter int unsigned NS_WRAP = 1_000_000_000
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [31:0]      wr_data,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns,
  input logic [SUB_W-1:0] act_sub,
  input logic [INC_W-1:0] act_ns
);
  import ptp_tod_pkg::*;

  AST_NS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_addr != A_NS) |=> (tod_ns < NS_WRAP)); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (act_ns == '0 && act_sub == '0 && !wr_en) |=> ($stable(tod_ns) && $stable(tod_sec))); // R2
  AST_SEC_HI_HELD: assert property (@(posedge clk) disable iff (rst)
    (act_ns == '0 && act_sub == '0 && wr_en && wr_addr == A_SEC_HI) |=> $stable(tod_sec)); // R3
  AST_SEC_LO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_SEC_LO) |=> (tod_sec[31:0] == $past(wr_data))); // R3
  AST_NS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_NS) |=> (tod_ns == $past(wr_data[NS_W-1:0]) && $stable(tod_sec))); // R4
  AST_SUB_PENDING: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_SUBNS) |=> $stable(act_sub)); // R5
  AST_INC_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_NSINC) |=> (act_ns == $past(wr_data[INC_W-1:0]))); // R5
  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R9
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R9
endmodule

bind ptp_tod_unit ptp_tod_chk #(
  .SEC_W(32 + SEC_HI_W), .NS_W(NS_W), .SUB_W(SUB_W), .INC_W(INC_W), .NS_WRAP(NS_WRAP)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_valid(rd_valid), .tod_sec(tod_sec), .tod_ns(tod_ns),
  .act_sub(act_sub), .act_ns(act_ns)
);

// File: tb/ptp_tod_unit_test.sv
module ptp_tod_unit_test;
  import ptp_tod_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  ptp_tod_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Scoreboard driver: push expected word, issue the read for one edge.
  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected read data actual=0x%0h expected=none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(rd_data), 64'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 sec", 64'(tod_sec), 64'd0);
    check("R1 ns", 64'(tod_ns), 64'd0);
    check("R1 rd_valid", 64'(rd_valid), 64'd0);
    rd(A_NSINC, 32'd0, "R1 ns step read");
    // R2: zero steps, time frozen
    idle(10);
    check("R2 ns frozen", 64'(tod_ns), 64'd0);
    check("R2 sec frozen", 64'(tod_sec), 64'd0);
    // R3: upper seconds held until low word written
    wr(A_SEC_HI, 32'h0000_0012);
    check("R3 hi write no effect", 64'(tod_sec), 64'd0);
    rd(A_SEC_HI, 32'd0, "R3 live upper seconds unchanged");
    wr(A_SEC_LO, 32'h89AB_CDEF);
    check("R3 seconds loaded", 64'(tod_sec), 64'h0012_89AB_CDEF);
    rd(A_SEC_HI, 32'h12, "R9 read upper seconds");
    rd(A_SEC_LO, 32'h89AB_CDEF, "R9 read lower seconds");
    // R4: ns load
    wr(A_NS, 32'd999_999_990);
    check("R4 ns loaded", 64'(tod_ns), 64'd999_999_990);
    check("R4 sec kept", 64'(tod_sec), 64'h0012_89AB_CDEF);
    rd(A_NS, 32'd999_999_990, "R9 read ns");
    // R5: sub-ns step (0x800000 = half ns) stays pending
    wr(A_SUBNS, 32'h0000_8000);
    idle(5);
    check("R5 pending no advance", 64'(tod_ns), 64'd999_999_990);
    rd(A_SUBNS, 32'd0, "R5 pending not active");
    // Commit 2.5 ns per edge; 11 stepping edges -> +27 ns, crosses a second
    wr(A_NSINC, 32'd2);
    rd(A_SUBNS, 32'h0000_8000, "R5 committed sub-ns layout");
    idle(8);
    wr(A_SUBNS, 32'd0);
    wr(A_NSINC, 32'd0);
    check("R6 ns after fractional steps", 64'(tod_ns), 64'd17);
    check("R7 second carry", 64'(tod_sec), 64'h0012_89AB_CDF0);
    idle(4);
    check("R2 stopped again", 64'(tod_ns), 64'd17);
    rd(A_NSINC, 32'd0, "R9 read ns step");
    // R8: one-shot signed adjust
    wr(A_ADJ, 32'd100);
    check("R8 add", 64'(tod_ns), 64'd117);
    idle(3);
    check("R8 applied once", 64'(tod_ns), 64'd117);
    wr(A_ADJ, 32'h8000_0000 | 32'd200);
    check("R8 subtract borrow ns", 64'(tod_ns), 64'd999_999_917);
    check("R8 subtract borrow sec", 64'(tod_sec), 64'h0012_89AB_CDEF);
    wr(A_ADJ, 32'd999_999_999);
    check("R8 add carry ns", 64'(tod_ns), 64'd999_999_916);
    check("R8 add carry sec", 64'(tod_sec), 64'h0012_89AB_CDF0);
    rd(A_ADJ, 32'd0, "R9 adjust reads zero");
    wr(A_NS, 32'd5);
    check("R4 ns reload", 64'(tod_ns), 64'd5);
    // R5 split layout: 0xAB001234 -> step 0x1234AB; 4 edges at 3 ns + small fraction
    wr(A_SUBNS, 32'hAB00_1234);
    wr(A_NSINC, 32'd3);
    rd(A_SUBNS, 32'hAB00_1234, "R5 split field readback");
    rd(A_NSINC, 32'd3, "R5 ns step readback");
    wr(A_SUBNS, 32'd0);
    wr(A_NSINC, 32'd0);
    check("R6 ns with no fraction carry", 64'(tod_ns), 64'd17);
    // R10: outputs move only at edges
    #2;
    check("R10 stable between edges", 64'(tod_ns), 64'd17);
    idle(3);
    check("R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule